// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block is a small register whose contents can be held, shifted toward the low end, shifted toward the high end, or replaced by a parallel word. A two-bit mode input is sampled on every rising clock edge and picks one of these four operations. During a shift, one serial input fills the vacated end: the high-end input for a right shift and the low-end input for a left shift. The register contents are always visible on a parallel output.

Each bit's next value comes from its own four-way selector, and the mode drives all the selectors. An asynchronous active-low clear sets the whole register to zero at once and overrides every mode. Typical uses are serial-to-parallel and parallel-to-serial conversion, serial accumulation paths and simple sequence generators built around a host that drives the mode.

Top module: `usr_shift_reg`

## Requirements
- R1: When `clr_n` goes low, `par_out` becomes all zeros at once, without waiting for a clock edge.
- R2: While `clr_n` is low, clock edges leave `par_out` at zero in every mode, including load (mode 3).
- R3: Mode 0 (`mode_sel`=2'b00) keeps `par_out` unchanged across a rising edge.
- R4: Mode 1 (`mode_sel`=2'b01) shifts right. Bit i takes the old bit i+1, and bit 3 takes `shift_in_hi`.
- R5: Mode 2 (`mode_sel`=2'b10) shifts left. Bit i takes the old bit i-1, and bit 0 takes `shift_in_lo`. For example, 1101 with `shift_in_lo`=1 gives 1011.
- R6: Mode 3 (`mode_sel`=2'b11) loads `par_in` into the register. For example, 0111 gives 0111 after the edge.
- R7: Changes to `mode_sel`, `par_in` and the serial inputs between rising edges do not affect `par_out`. Only the values present at a rising edge take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | Operation select: 0 hold, 1 right, 2 left, 3 load |
| par_in | input | 4 | Parallel load word |
| shift_in_hi | input | 1 | Serial bit entering bit 3 on a right shift |
| shift_in_lo | input | 1 | Serial bit entering bit 0 on a left shift |
| par_out | output | 4 | Register contents |

## Verification
The case that is hardest to reach from the ports is a clear that arrives between clock edges. Its effect has to be seen before any edge occurs, and it has to beat a load that is pending at the next edge. The bench drops `clr_n` partway through a cycle while a nonzero load word and the load mode are already on the inputs. It checks for zero before the next edge, and again after edges taken while the clear is still held. Every other case comes from a full sweep: each start value is preloaded, then each mode is applied with every data word and every pair of serial bits.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_e;

    // Candidate sources for one register bit
    typedef struct packed {
        logic load;
        logic left;
        logic right;
        logic hold;
    } taps_t;

    function automatic logic pick_tap(taps_t t, mode_e m);
        logic r;
        unique case (m)
            MODE_HOLD: r = t.hold;
            MODE_SHR:  r = t.right;
            MODE_SHL:  r = t.left;
            default:   r = t.load;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usr_mux4.sv
module usr_mux4
    import usr_pkg::*;
(
    input  taps_t taps,
    input  mode_e sel,
    output logic  y
);
    always_comb y = pick_tap(taps, sel);
endmodule

// File: rtl/usr_next.sv
module usr_next
    import usr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] load_val,
    input  logic         fill_hi,
    input  logic         fill_lo,
    input  mode_e        sel,
    output logic [W-1:0] nxt
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        taps_t t;
        logic  from_above;
        logic  from_below;

        if (i == W-1) begin : g_top
            assign from_above = fill_hi;
        end else begin : g_mid_hi
            assign from_above = cur[i+1];
        end

        if (i == 0) begin : g_bot
            assign from_below = fill_lo;
        end else begin : g_mid_lo
            assign from_below = cur[i-1];
        end

        assign t.hold  = cur[i];
        assign t.right = from_above;
        assign t.left  = from_below;
        assign t.load  = load_val[i];

        usr_mux4 u_mux (
            .taps (t),
            .sel  (sel),
            .y    (nxt[i])
        );
    end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [1:0]   mode_sel,
    input  logic [W-1:0] par_in,
    input  logic         shift_in_hi,
    input  logic         shift_in_lo,
    output logic [W-1:0] par_out
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    mode_e        mode;

    assign mode = mode_e'(mode_sel);

    usr_next #(.W(W)) u_next (
        .cur      (state_q),
        .load_val (par_in),
        .fill_hi  (shift_in_hi),
        .fill_lo  (shift_in_lo),
        .sel      (mode),
        .nxt      (state_d)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign par_out = state_q;
endmodule

// File: rtl/usr_shift_reg_sva.sv
module usr_shift_reg_sva #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic [1:0]   mode_sel,
    input logic [W-1:0] par_in,
    input logic         shift_in_hi,
    input logic         shift_in_lo,
    input logic [W-1:0] par_out
);
    // R1 / R2: output is zero whenever clear is active at an edge
    always @(posedge clk) begin
        if (!clr_n) p_clear_zero_r2: assert (par_out == '0);
    end

    p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_sel == 2'b00) |=> (par_out == $past(par_out)));

    p_shr_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_sel == 2'b01) |=> (par_out == {$past(shift_in_hi), $past(par_out[W-1:1])}));

    p_shl_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_sel == 2'b10) |=> (par_out == {$past(par_out[W-2:0]), $past(shift_in_lo)}));

    p_load_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (mode_sel == 2'b11) |=> (par_out == $past(par_in)));
endmodule

bind usr_shift_reg usr_shift_reg_sva #(.W(W)) u_sva (
    .clk         (clk),
    .clr_n       (clr_n),
    .mode_sel    (mode_sel),
    .par_in      (par_in),
    .shift_in_hi (shift_in_hi),
    .shift_in_lo (shift_in_lo),
    .par_out     (par_out)
);

// File: tb/tb_usr_shift_reg.sv
`timescale 1ns/1ps
module tb_usr_shift_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   mode_sel;
    logic [W-1:0] par_in;
    logic         shift_in_hi;
    logic         shift_in_lo;
    logic [W-1:0] par_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    usr_shift_reg #(.W(W)) dut (
        .clk         (clk),
        .clr_n       (clr_n),
        .mode_sel    (mode_sel),
        .par_in      (par_in),
        .shift_in_hi (shift_in_hi),
        .shift_in_lo (shift_in_lo),
        .par_out     (par_out)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] q, logic [1:0] m,
                                           logic [W-1:0] d, logic hi, logic lo);
        logic [W-1:0] r;
        r = q;
        for (int i = 0; i < W; i++) begin
            case (m)
                2'd0: r[i] = q[i];
                2'd1: r[i] = (i == W-1) ? hi : q[(i+1) % W];
                2'd2: r[i] = (i == 0) ? lo : q[(i+W-1) % W];
                default: r[i] = d[i];
            endcase
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] exp);
        total++;
        if (par_out !== exp) begin
            bad++;
            $display("FAIL %s: par_out=%b expected=%b", req, par_out, exp);
        end
    endtask

    // drive away from edge, take one rising edge, sample 2 ns later
    task automatic step(logic [1:0] m, logic [W-1:0] d, logic hi, logic lo);
        mode_sel = m; par_in = d; shift_in_hi = hi; shift_in_lo = lo;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] exp;
        clr_n = 1'b0; mode_sel = 2'b11; par_in = 4'b1010;
        shift_in_hi = 1'b1; shift_in_lo = 1'b1;
        #3;
        check("R1 reset state", '0);
        @(posedge clk); #2;
        check("R2 load blocked under clear", '0);
        @(posedge clk); #2;
        clr_n = 1'b1;

        // document examples
        step(2'b11, 4'b0111, 0, 0);
        check("R6 load 0111", 4'b0111);
        step(2'b11, 4'b1101, 0, 0);
        step(2'b10, 4'b0000, 0, 1);
        check("R5 1101 left with 1", 4'b1011);

        // exhaustive sweep: start value x mode x data x serial pair
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 16; d++) begin
                    for (int sp = 0; sp < 4; sp++) begin
                        step(2'b11, W'(s), 0, 0);
                        exp = model(W'(s), 2'(m), W'(d), sp[1], sp[0]);
                        step(2'(m), W'(d), sp[1], sp[0]);
                        case (m)
                            0: check("R3 hold", exp);
                            1: check("R4 shift right", exp);
                            2: check("R5 shift left", exp);
                            default: check("R6 load", exp);
                        endcase
                    end
                end
            end
        end

        // R7: inputs wiggle between edges, only edge values matter
        step(2'b11, 4'b1001, 0, 0);
        mode_sel = 2'b11; par_in = 4'b0110;
        #1; mode_sel = 2'b01; shift_in_hi = 1'b1;
        #1; check("R7 no change between edges", 4'b1001);
        mode_sel = 2'b00; par_in = 4'b1111;
        @(posedge clk); #2;
        check("R7 edge value applies", 4'b1001);

        // R1 mid-cycle clear with a load pending
        step(2'b11, 4'b1110, 0, 0);
        mode_sel = 2'b11; par_in = 4'b0101;
        @(negedge clk); #1;
        clr_n = 1'b0;
        #0.5;
        check("R1 async clear before edge", '0);
        @(posedge clk); #2;
        check("R2 clear holds over load", '0);
        mode_sel = 2'b01; shift_in_hi = 1'b1;
        @(posedge clk); #2;
        check("R2 clear holds over shift", '0);
        clr_n = 1'b1;
        step(2'b01, 4'b0000, 1, 0);
        check("R4 after clear release", 4'b1000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule